// File: doc/BRIEF.md
# Accumulator Machine Core

This block is a small one-address processor. Every computation passes through a single accumulator register. An instruction is one 16-bit word. Its top three bits select the operation and its low eight bits name one memory word. LOAD copies that word into the accumulator and STORE writes the accumulator out to it. ADD, SUB and MUL combine the accumulator with the named word and put the result back into the accumulator.

Instructions and data share one memory port, and the port reads combinationally. Each instruction therefore takes two cycles:

- In the fetch cycle the port carries the program counter, and the word read is latched as the current instruction.
- In the execute cycle the port carries the operand address, and the core either reads the operand or drives a write.

A HALT instruction parks the core until the next reset.

Top module: `acc_cpu`

## Requirements
- R1: While reset (active-low, asynchronous) is asserted, `halt` and `mem_we` are 0 and `mem_addr` is 0. After reset the accumulator holds 0 and the first fetch reads address 0.
- R2: The core alternates a fetch cycle and an execute cycle. In a fetch cycle `mem_addr` equals the program counter and `mem_we` is 0. In the execute cycle that follows, `mem_addr` equals instruction bits [7:0].
- R3: LOAD (opcode bits [15:13] = 3'b001) sets the accumulator to the word at the operand address.
- R4: STORE (opcode 3'b010) raises `mem_we` for exactly one cycle, the execute cycle, with `mem_addr` = operand address and `mem_wdata` = accumulator.
- R5: ADD (opcode 3'b011) sets the accumulator to accumulator + memory word, modulo 2^16.
- R6: SUB (opcode 3'b100) sets the accumulator to accumulator − memory word, modulo 2^16. The accumulator is the minuend.
- R7: MUL (opcode 3'b101) sets the accumulator to the low 16 bits of accumulator × memory word (unsigned).
- R8: HALT (opcode 3'b111) sets `halt` after its execute cycle. From then until reset, `halt` stays 1, `mem_we` stays 0, `mem_addr` does not change, and no later instruction runs.
- R9: Opcodes 3'b000 and 3'b110 leave the accumulator and memory unchanged and only advance the program counter.
- R10: The 8-bit program counter increments by one per instruction and wraps from 255 to 0.
- R11: Instruction bits [12:8] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 8 | Shared memory address: program counter in fetch, operand address in execute |
| mem_wdata | output | 16 | Write data, always the accumulator |
| mem_we | output | 1 | Memory write strobe, high only while a STORE executes |
| mem_rdata | input | 16 | Combinational read data for `mem_addr` |
| halt | output | 1 | High once a HALT has executed, until reset |

## Verification
The bench aims at the following corner cases:

- **Arithmetic wrap.** ADD runs past 0xFFFF and SUB goes below zero. A core with a widened or sign-handled accumulator would store the wrong word.
- **SUB operand order.** The two SUB operands are chosen so that swapping minuend and subtrahend gives a visibly different result.
- **MUL truncation.** MUL uses operands whose product spills past 16 bits, so keeping the wrong half of the product shows up.
- **Code after HALT.** A STORE placed directly after HALT catches a core that keeps running.
- **Program counter wrap.** A self-modifying program only halts if the counter wraps from 255 back to 0 and re-fetches address 0. A counter that sticks or grows wider never halts.
- **Ignored opcodes and bits.** The same program checks that the two unused opcodes and the ignored middle bits disturb neither the accumulator nor memory.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int DW  = 16,
  parameter int AW  = 8,
  parameter int OPW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  output logic          halt
);
  localparam logic [OPW-1:0] OP_LOAD  = OPW'(1);
  localparam logic [OPW-1:0] OP_STORE = OPW'(2);
  localparam logic [OPW-1:0] OP_ADD   = OPW'(3);
  localparam logic [OPW-1:0] OP_SUB   = OPW'(4);
  localparam logic [OPW-1:0] OP_MUL   = OPW'(5);
  localparam logic [OPW-1:0] OP_HALT  = OPW'(7);

  typedef enum logic [1:0] {S_FETCH, S_EXEC, S_HALT} state_t;

  state_t          state;
  logic [AW-1:0]   pc;
  logic [DW-1:0]   ir;
  logic [DW-1:0]   acc;
  logic [OPW-1:0]  op;
  logic [AW-1:0]   opnd;
  logic [2*DW-1:0] prod;

  assign op        = ir[DW-1 -: OPW];
  assign opnd      = ir[AW-1:0];
  assign prod      = {{DW{1'b0}}, acc} * {{DW{1'b0}}, mem_rdata};
  assign mem_addr  = (state == S_EXEC) ? opnd : pc;
  assign mem_we    = (state == S_EXEC) && (op == OP_STORE);
  assign mem_wdata = acc;
  assign halt      = (state == S_HALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_FETCH;
      pc    <= '0;
      ir    <= '0;
      acc   <= '0;
    end else begin
      case (state)
        S_FETCH: begin
          ir    <= mem_rdata;
          pc    <= pc + 1'b1;
          state <= S_EXEC;
        end
        S_EXEC: begin
          state <= S_FETCH;
          case (op)
            OP_LOAD: acc   <= mem_rdata;
            OP_ADD:  acc   <= acc + mem_rdata;
            OP_SUB:  acc   <= acc - mem_rdata;
            OP_MUL:  acc   <= prod[DW-1:0];
            OP_HALT: state <= S_HALT;
            default: ;
          endcase
        end
        default: state <= S_HALT;
      endcase
    end
  end
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_we,
  input logic [DW-1:0] mem_rdata,
  input logic          halt
);
  logic          phase;
  logic          seen;
  logic [AW-1:0] last_fetch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= 1'b0;
      seen       <= 1'b0;
      last_fetch <= '0;
    end else if (!halt) begin
      phase <= ~phase;
      if (!phase) begin
        last_fetch <= mem_addr;
        seen       <= 1'b1;
      end
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (!mem_we && !halt && mem_addr == '0)); // R1
  AST_FETCH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (!phase && !halt) |-> !mem_we); // R2
  AST_STORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) mem_we |=> !mem_we); // R4
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) halt |=> halt); // R8
  AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) halt |-> !mem_we); // R8
  AST_HALT_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n) (halt && $past(halt)) |-> $stable(mem_addr)); // R8
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n) (!phase && !halt && seen) |-> mem_addr == last_fetch + AW'(1)); // R10

  logic unused_ok;
  assign unused_ok = ^{mem_wdata, mem_rdata};
endmodule

bind acc_cpu acc_cpu_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_we(mem_we), .mem_rdata(mem_rdata), .halt(halt)
);

// File: tb/tb_acc_cpu.sv
module tb_acc_cpu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [15:0] mem_rdata;
  logic        halt;

  logic [15:0] mem [0:255];
  int          wr_count = 0;
  int          n_checks = 0;
  int          n_fail = 0;
  int          cycles = 0;

  always #2 clk = ~clk;

  acc_cpu dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .halt(halt)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wr_count      <= wr_count + 1;
    end
  end

  localparam logic [2:0] NOP0 = 3'd0, LD = 3'd1, ST = 3'd2, AD = 3'd3,
                         SB = 3'd4, ML = 3'd5, NOP6 = 3'd6, HLT = 3'd7;

  function automatic logic [15:0] ins(input logic [2:0] op, input logic [7:0] a);
    return {op, 5'b00000, a};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  task automatic start();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_halt(input string req, input int limit);
    int n = 0;
    while (!halt && n < limit) begin
      @(negedge clk);
      n++;
    end
    chk(req, halt, 1'b1);
  endtask

  task automatic t_load_store();
    hold_reset();
    clear_mem();
    mem[8'h40] = 16'h1234;
    mem[0] = ins(LD, 8'h40);
    mem[1] = ins(ST, 8'h41);
    mem[2] = ins(HLT, 8'h00);
    start();
    wait_halt("R3 load/store halts", 50);
    chk("R3 loaded word stored", mem[8'h41], 16'h1234);
  endtask

  task automatic t_reset_phase();
    hold_reset();
    clear_mem();
    mem[8'h80] = 16'hBEEF;
    mem[0] = ins(ST, 8'h80);
    mem[1] = ins(HLT, 8'h00);
    chk("R1 halt low in reset", halt, 1'b0);
    chk("R1 we low in reset", mem_we, 1'b0);
    chk("R1 addr zero in reset", mem_addr, 8'h00);
    start();
    chk("R2 first fetch address", mem_addr, 8'h00);
    chk("R2 no write in fetch", mem_we, 1'b0);
    @(negedge clk);
    chk("R2 execute drives operand address", mem_addr, 8'h80);
    chk("R4 write strobe in execute", mem_we, 1'b1);
    chk("R1 accumulator cleared by reset", mem_wdata, 16'h0000);
    @(negedge clk);
    chk("R4 strobe lasts one cycle", mem_we, 1'b0);
    chk("R2 next fetch address", mem_addr, 8'h01);
    @(negedge clk);
    chk("R8 halt not yet set during its execute", halt, 1'b0);
    @(negedge clk);
    chk("R8 halt set after execute", halt, 1'b1);
    chk("R4 stored value", mem[8'h80], 16'h0000);
  endtask

  task automatic t_add();
    hold_reset();
    clear_mem();
    mem[8'h50] = 16'hFFF0;
    mem[8'h51] = 16'h0020;
    mem[8'h52] = 16'h0101;
    mem[0] = ins(LD, 8'h50);
    mem[1] = ins(AD, 8'h51);
    mem[2] = ins(ST, 8'h60);
    mem[3] = ins(AD, 8'h52);
    mem[4] = ins(ST, 8'h61);
    mem[5] = ins(HLT, 8'h00);
    start();
    wait_halt("R5 add halts", 50);
    chk("R5 add wraps", mem[8'h60], 16'h0010);
    chk("R5 add chain", mem[8'h61], 16'h0111);
  endtask

  task automatic t_sub();
    hold_reset();
    clear_mem();
    mem[8'h50] = 16'h0005;
    mem[8'h51] = 16'h0007;
    mem[0] = ins(LD, 8'h50);
    mem[1] = ins(SB, 8'h51);
    mem[2] = ins(ST, 8'h60);
    mem[3] = ins(LD, 8'h51);
    mem[4] = ins(SB, 8'h50);
    mem[5] = ins(ST, 8'h61);
    mem[6] = ins(HLT, 8'h00);
    start();
    wait_halt("R6 sub halts", 50);
    chk("R6 sub borrow wraps", mem[8'h60], 16'hFFFE);
    chk("R6 sub acc is minuend", mem[8'h61], 16'h0002);
  endtask

  task automatic t_mul();
    hold_reset();
    clear_mem();
    mem[8'h50] = 16'h1234;
    mem[8'h51] = 16'h0100;
    mem[8'h52] = 16'hFFFF;
    mem[0] = ins(LD, 8'h50);
    mem[1] = ins(ML, 8'h51);
    mem[2] = ins(ST, 8'h60);
    mem[3] = ins(LD, 8'h52);
    mem[4] = ins(ML, 8'h52);
    mem[5] = ins(ST, 8'h61);
    mem[6] = ins(HLT, 8'h00);
    start();
    wait_halt("R7 mul halts", 50);
    chk("R7 mul low half", mem[8'h60], 16'h3400);
    chk("R7 mul all ones", mem[8'h61], 16'h0001);
  endtask

  task automatic t_halt();
    int w0;
    logic [7:0] a0;
    hold_reset();
    clear_mem();
    mem[8'h50] = 16'h00AA;
    mem[0] = ins(LD, 8'h50);
    mem[1] = ins(HLT, 8'h00);
    mem[2] = ins(ST, 8'h60);
    mem[3] = ins(ST, 8'h61);
    start();
    wait_halt("R8 halt reached", 50);
    w0 = wr_count;
    a0 = mem_addr;
    for (int i = 0; i < 12; i++) @(negedge clk);
    chk("R8 halt stays high", halt, 1'b1);
    chk("R8 no writes after halt", wr_count - w0, 0);
    chk("R8 address held", mem_addr, a0);
    chk("R8 following store not run", mem[8'h60], 16'h0000);
  endtask

  task automatic t_undef();
    hold_reset();
    clear_mem();
    mem[8'h50] = 16'h5A5A;
    mem[8'h51] = 16'h0F0F;
    mem[0] = ins(LD, 8'h50);
    mem[1] = ins(NOP0, 8'h51);
    mem[2] = ins(NOP6, 8'h51);
    mem[3] = ins(ST, 8'h60);
    mem[4] = {AD, 5'b10101, 8'h51};
    mem[5] = {ST, 5'b11111, 8'h61};
    mem[6] = ins(HLT, 8'h00);
    start();
    wait_halt("R9 undefined program halts", 50);
    chk("R9 acc kept across unused opcodes", mem[8'h60], 16'h5A5A);
    chk("R9 operand word untouched", mem[8'h51], 16'h0F0F);
    chk("R11 middle bits ignored", mem[8'h61], 16'h6969);
  endtask

  task automatic t_wrap();
    hold_reset();
    clear_mem();
    mem[250] = ins(LD, 8'd254);
    mem[251] = ins(AD, 8'd255);
    mem[252] = ins(ST, 8'd0);
    mem[254] = 16'h1F00;
    mem[255] = 16'hC100;
    start();
    wait_halt("R10 counter wraps and re-fetches address 0", 700);
    chk("R10 built halt word at 0", mem[0], 16'hE000);
    chk("R10 halt parks at address 1", mem_addr, 8'h01);
  endtask

  initial begin
    clear_mem();
    t_load_store();
    t_reset_phase();
    t_add();
    t_sub();
    t_mul();
    t_halt();
    t_undef();
    t_wrap();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #400000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=<100000 cycles", cycles);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule